// File: doc/BRIEF.md
# Pixel to Byte-Lane Serializer

This block sits on the host side of a reduced-pin display link. It accepts one pixel at a time, made of three colour components, together with line sync, frame sync and data-enable. It then sends the pixel over a narrow byte lane, one component per clock cycle. The byte clock therefore runs at three times the pixel rate: for example, a 100 MHz lane carries a 33.3 MHz pixel stream.

The receiver finds the colour phase from the edges of the line-sync wire. For that reason the block lets line sync change only in the cycle that carries a pixel's blue byte. Sync and enable levels are captured together with the pixel and held for all three of its cycles. When no pixel is offered at a boundary, the block fills the slot with zero bytes and drops the enable.

Top module: `pix_byte_ser`

## Requirements
- R1: A pixel accepted on a rising edge appears on the lane as three consecutive cycles in the order blue, green, red. Blue is driven in the first cycle after the accepting edge.
- R2: `pix_ready` is high in exactly one cycle of every three, which is the cycle just before a blue cycle. After reset is released, it first rises in the third cycle.
- R3: Pixel inputs presented while `pix_ready` is low are ignored. They are not accepted and do not alter the bytes already in flight.
- R4: `lane_line_sync` changes only in blue cycles, and it takes the line-sync level that was presented with the accepted pixel.
- R5: If `pix_valid` is low while `pix_ready` is high, the next three lane cycles carry zero bytes with `lane_den` low, and both sync outputs keep their previous levels.
- R6: `lane_frame_sync` and `lane_den` are captured at acceptance and held for all three cycles of the pixel. Changes requested in the middle of a pixel take effect only at the next boundary.
- R7: While `rst_n` is low, the lane data, all sync outputs, `lane_den` and `pix_ready` are all zero, and the phase is set to the blue phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock, rising-edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | A pixel is offered |
| pix_ready | output | 1 | The pixel is taken on this edge if valid |
| pix_red | input | CW | Red component |
| pix_green | input | CW | Green component |
| pix_blue | input | CW | Blue component |
| line_sync_in | input | 1 | Line-sync level for the offered pixel |
| frame_sync_in | input | 1 | Frame-sync level for the offered pixel |
| den_in | input | 1 | Data-enable for the offered pixel |
| lane_data | output | CW | Serialized component byte |
| lane_line_sync | output | 1 | Registered line sync, changes only with blue |
| lane_frame_sync | output | 1 | Registered frame sync |
| lane_den | output | 1 | Registered data-enable |

## Verification
The bench builds the block with its default component width of 8. At this width, random byte values exercise every data bit across all three phases. The stimulus toggles the sync and enable inputs on every cycle, including mid-pixel cycles, so that both the boundary-only latching and the blue-only line-sync rule are tested. It also mixes back-to-back pixels, sparse offers and long idle stretches, which brings the zero-fill slots and the held sync levels within reach.

// File: rtl/pix_byte_ser.sv
module pix_byte_ser #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_valid,
  output logic          pix_ready,
  input  logic [CW-1:0] pix_red,
  input  logic [CW-1:0] pix_green,
  input  logic [CW-1:0] pix_blue,
  input  logic          line_sync_in,
  input  logic          frame_sync_in,
  input  logic          den_in,
  output logic [CW-1:0] lane_data,
  output logic          lane_line_sync,
  output logic          lane_frame_sync,
  output logic          lane_den
);
  localparam logic [1:0] PH_BLUE  = 2'd0;
  localparam logic [1:0] PH_GREEN = 2'd1;
  localparam logic [1:0] PH_RED   = 2'd2;

  logic [1:0]    ph;
  logic [CW-1:0] hold_g, hold_r, data_q;
  logic          ls_q, fs_q, den_q;
  logic          take;

  assign pix_ready = (ph == PH_RED);
  assign take      = pix_ready && pix_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= PH_BLUE;
      hold_g <= '0;
      hold_r <= '0;
      data_q <= '0;
      ls_q   <= 1'b0;
      fs_q   <= 1'b0;
      den_q  <= 1'b0;
    end else begin
      case (ph)
        PH_RED: begin
          ph <= PH_BLUE;
          if (take) begin
            data_q <= pix_blue;
            hold_g <= pix_green;
            hold_r <= pix_red;
            ls_q   <= line_sync_in;
            fs_q   <= frame_sync_in;
            den_q  <= den_in;
          end else begin
            data_q <= '0;
            hold_g <= '0;
            hold_r <= '0;
            den_q  <= 1'b0;
          end
        end
        PH_BLUE: begin
          ph     <= PH_GREEN;
          data_q <= hold_g;
        end
        default: begin
          ph     <= PH_RED;
          data_q <= hold_r;
        end
      endcase
    end
  end

  assign lane_data       = data_q;
  assign lane_line_sync  = ls_q;
  assign lane_frame_sync = fs_q;
  assign lane_den        = den_q;
endmodule

// File: rtl/pix_byte_ser_chk.sv
module pix_byte_ser_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_valid,
  input logic          pix_ready,
  input logic [CW-1:0] pix_red,
  input logic [CW-1:0] pix_green,
  input logic [CW-1:0] pix_blue,
  input logic [CW-1:0] lane_data,
  input logic          lane_line_sync,
  input logic          lane_frame_sync,
  input logic          lane_den
);
  logic [1:0] cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= 2'd0;
    else if (cnt == 2'd2) cnt <= 2'd0;
    else                  cnt <= cnt + 2'd1;
  end

  AST_READY_CADENCE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready == (cnt == 2'd2)); // R2
  AST_BLUE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ready && pix_valid) |=> (lane_data == $past(pix_blue))); // R1
  AST_GREEN_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ready && pix_valid) |=> ##1 (lane_data == $past(pix_green, 2))); // R1
  AST_RED_THIRD: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ready && pix_valid) |=> ##2 (lane_data == $past(pix_red, 3))); // R1
  AST_LINE_SYNC_ON_BLUE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != 2'd0) |-> $stable(lane_line_sync)); // R4
  AST_HOLD_MID_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != 2'd0) |-> ($stable(lane_frame_sync) && $stable(lane_den))); // R6
  AST_IDLE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ready && !pix_valid) |=> (lane_data == '0 && !lane_den &&
      $stable(lane_line_sync) && $stable(lane_frame_sync))); // R5
endmodule

bind pix_byte_ser pix_byte_ser_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
  .pix_red(pix_red), .pix_green(pix_green), .pix_blue(pix_blue),
  .lane_data(lane_data), .lane_line_sync(lane_line_sync),
  .lane_frame_sync(lane_frame_sync), .lane_den(lane_den)
);

// File: tb/pix_byte_ser_bench.sv
module pix_byte_ser_bench;
  localparam int CW = 8;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, pix_valid, pix_ready, line_sync_in, frame_sync_in, den_in;
  logic [CW-1:0] pix_red, pix_green, pix_blue, lane_data;
  logic lane_line_sync, lane_frame_sync, lane_den;

  pix_byte_ser #(.CW(CW)) u_pix_byte_ser (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_red(pix_red), .pix_green(pix_green), .pix_blue(pix_blue),
    .line_sync_in(line_sync_in), .frame_sync_in(frame_sync_in), .den_in(den_in),
    .lane_data(lane_data), .lane_line_sync(lane_line_sync),
    .lane_frame_sync(lane_frame_sync), .lane_den(lane_den)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // behavioural reference: a byte queue and a modulo-3 slot count
  int m_slot;
  logic [CW-1:0] q[$];
  logic [CW-1:0] e_data;
  logic e_ls, e_fs, e_den;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_slot = 0; q.delete(); e_data = '0; e_ls = 0; e_fs = 0; e_den = 0;
    end else begin
      if (m_slot == 2) begin
        if (pix_valid) begin
          q.push_back(pix_blue); q.push_back(pix_green); q.push_back(pix_red);
          e_ls = line_sync_in; e_fs = frame_sync_in; e_den = den_in;
        end else begin
          q.push_back('0); q.push_back('0); q.push_back('0);
          e_den = 0;
        end
      end
      m_slot = (m_slot + 1) % 3;
      e_data = (q.size() > 0) ? q.pop_front() : '0;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 R3 lane_data", 32'(lane_data), 32'(e_data));
    chk("R2 pix_ready", 32'(pix_ready), 32'(m_slot == 2));
    chk("R4 lane_line_sync", 32'(lane_line_sync), 32'(e_ls));
    chk("R6 lane_frame_sync", 32'(lane_frame_sync), 32'(e_fs));
    chk("R5 R6 lane_den", 32'(lane_den), 32'(e_den));
  endtask

  task automatic drive(int mode);
    pix_red   = CW'($urandom);
    pix_green = CW'($urandom);
    pix_blue  = CW'($urandom);
    line_sync_in  = 1'($urandom);
    frame_sync_in = 1'($urandom);
    den_in        = 1'($urandom);
    case (mode)
      0: pix_valid = 1'b1;
      1: pix_valid = ($urandom % 3) == 0;
      default: pix_valid = 1'b0;
    endcase
  endtask

  initial begin
    void'($urandom(7));
    rst_n = 0; pix_valid = 1; pix_red = 8'hAA; pix_green = 8'h55; pix_blue = 8'hC3;
    line_sync_in = 1; frame_sync_in = 1; den_in = 1;
    repeat (4) @(negedge clk);
    // R7: reset state
    chk("R7 reset lane_data", 32'(lane_data), 0);
    chk("R7 reset pix_ready", 32'(pix_ready), 0);
    chk("R7 reset syncs", 32'({lane_line_sync, lane_frame_sync, lane_den}), 0);
    rst_n = 1;
    for (int seg = 0; seg < 9; seg++) begin
      for (int c = 0; c < 90; c++) begin
        @(negedge clk);
        compare_all();
        drive(seg % 3);
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule